// File: doc/BRIEF.md
# UART Sampling-Rate Tick Generator

This block turns a reference clock into the 16x oversampling enable that a UART transmitter and receiver use. The reference is first reduced by a fixed-choice prescaler, either 1 or 4, picked by a single control input. It is then counted down by a 16-bit divisor. The host loads the divisor one byte at a time through two write strobes, one for the low byte and one for the high byte, which share a data bus.

The output is an enable pulse that lasts one reference-clock cycle. It is not a derived clock, so all downstream logic stays in the reference domain. Any divisor write restarts the prescaler and the divisor count. The first tick at the new rate therefore comes a full period after the write and is never clipped. A divisor of zero stops the tick. To get a serial rate B from reference frequency F with prescale P, the host programs F / (P x 16 x B). With a 14.7456 MHz reference, a divisor of 1 with prescale 1 gives 921.6 kbit/s.

Top module: `baud_tick_gen`

## Requirements
- R1: Reset clears both divisor bytes to zero and holds `tick` low. After reset releases, no tick appears until a non-zero divisor is written.
- R2: The divisor is {high byte, low byte}. A cycle with `wrHi` high loads `wrData` into the high byte only, and a cycle with `wrLo` high loads it into the low byte only. The byte that is not written keeps its value.
- R3: With `prescaleSel` = 0 (divide by 1) and divisor N > 0, `tick` repeats every N reference cycles.
- R4: With `prescaleSel` = 1 (divide by 4) and divisor N > 0, `tick` repeats every 4N reference cycles.
- R5: While the divisor is zero, `tick` stays low whatever `prescaleSel` is.
- R6: A write to either byte restarts the count. `tick` is low in the cycle after the write edge. The first tick is seen after exactly N*P rising edges following the write edge, where P is the prescale ratio.
- R7: When N*P > 1, `tick` is high for exactly one reference cycle per period.
- R8: Divisor 0x0900 with `prescaleSel` = 1 gives a tick every 9216 cycles. Divisor 1 with `prescaleSel` = 0 gives a tick in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prescaleSel | input | 1 | 0: divide by 1, 1: divide by 4 ahead of the divisor |
| wrLo | input | 1 | Write strobe for the divisor low byte |
| wrHi | input | 1 | Write strobe for the divisor high byte |
| wrData | input | 8 | Write data for either byte |
| tick | output | 1 | One-cycle 16x sampling-rate enable |

## Verification
The bench sweeps every divisor from 1 to 12 under both prescale settings. For each case it measures the distance from the write to the first tick, then two tick-to-tick gaps. An off-by-one in the terminal count, or a prescaler that steps at the wrong ratio, gives a distinct wrong number of cycles. Large divisors are also tried: 0x0900 under divide-by-4, and a high-byte-only update that produces 0x0105. These show whether each byte lands in the right half and whether the unwritten byte is kept. A zero divisor and a reset taken in the middle of a count show whether the block really goes silent.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // Strobes passed from control to the divisor datapath each cycle
  typedef struct packed {
    logic reload;  // a divisor byte was written: restart counting
    logic step;    // prescaler output enable
  } baudStrobe_t;
endpackage

// File: rtl/baud_ctl.sv
module baud_ctl
  import baud_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PRE_DIV = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prescaleSel,
  input  logic                  wrLo,
  input  logic                  wrHi,
  input  logic [BYTE_W-1:0]     wrData,
  output logic [2*BYTE_W-1:0]   divisor,
  output baudStrobe_t           strobes
);
  localparam int NUM_BYTES = 2;
  localparam int PRE_W     = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [NUM_BYTES-1:0] wrVec;
  logic [PRE_W-1:0]     preCnt;
  logic                 reloadNow;

  assign wrVec     = {wrHi, wrLo};
  assign reloadNow = |wrVec;

  // Divisor byte registers, byte 0 is the low half
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] byteQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        byteQ <= '0;
      else if (wrVec[b]) byteQ <= wrData;
    end
    assign divisor[b*BYTE_W +: BYTE_W] = byteQ;
  end

  // Prescaler phase counter, restarted by any divisor write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                preCnt <= '0;
    else if (reloadNow)        preCnt <= '0;
    else if (preCnt == PRE_LAST) preCnt <= '0;
    else                       preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    strobes.reload = reloadNow;
    strobes.step   = prescaleSel ? (preCnt == PRE_LAST) : 1'b1;
  end
endmodule

// File: rtl/baud_div.sv
module baud_div
  import baud_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  baudStrobe_t      strobes,
  output logic [DIV_W-1:0] divCount,
  output logic             tick
);
  logic             enabled;
  logic             atLast;
  logic [DIV_W-1:0] cntQ;

  assign enabled  = (divisor != '0);
  assign atLast   = (cntQ == divisor - 1'b1);
  assign divCount = cntQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ <= '0;
      tick <= 1'b0;
    end else if (strobes.reload) begin
      cntQ <= '0;
      tick <= 1'b0;
    end else if (strobes.step && enabled) begin
      cntQ <= atLast ? '0 : cntQ + 1'b1;
      tick <= atLast;
    end else begin
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PRE_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prescaleSel,
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic [BYTE_W-1:0] wrData,
  output logic              tick
);
  localparam int DIV_W = 2 * BYTE_W;

  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] divCount;
  baudStrobe_t      strobes;

  baud_ctl #(.BYTE_W(BYTE_W), .PRE_DIV(PRE_DIV)) u_ctl (
    .clk(clk), .rst_n(rst_n), .prescaleSel(prescaleSel),
    .wrLo(wrLo), .wrHi(wrHi), .wrData(wrData),
    .divisor(divisor), .strobes(strobes)
  );

  baud_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .strobes(strobes),
    .divCount(divCount), .tick(tick)
  );
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prescaleSel,
  input logic             wrLo,
  input logic             wrHi,
  input logic             tick,
  input logic             stepStb,
  input logic [DIV_W-1:0] divisor,
  input logic [DIV_W-1:0] divCount
);
  p_silent_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |=> !tick);

  p_reload_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrLo || wrHi) |=> (!tick && divCount == '0));

  p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor != '0) |-> (divCount < divisor));

  p_idle_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> (divCount == '0));

  p_unity_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !prescaleSel |-> stepStb);

  p_step_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (prescaleSel && stepStb) |=> !(prescaleSel && stepStb));

  p_tick_needs_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stepStb |=> !tick);
endmodule

bind baud_tick_gen baud_tick_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prescaleSel(prescaleSel),
  .wrLo(wrLo), .wrHi(wrHi), .tick(tick), .stepStb(strobes.step),
  .divisor(divisor), .divCount(divCount)
);

// File: tb/baud_tick_gen_tb.sv
`timescale 1ns/1ps
module baud_tick_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prescaleSel = 1'b0;
  logic       wrLo = 1'b0;
  logic       wrHi = 1'b0;
  logic [7:0] wrData = '0;
  logic       tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  baud_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .prescaleSel(prescaleSel),
    .wrLo(wrLo), .wrHi(wrHi), .wrData(wrData), .tick(tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic writeDiv(input logic [15:0] value);
    @(negedge clk); wrHi = 1'b1; wrData = value[15:8];
    @(negedge clk); wrHi = 1'b0; wrLo = 1'b1; wrData = value[7:0];
    @(negedge clk); wrLo = 1'b0;
  endtask

  task automatic writeHiOnly(input logic [7:0] value);
    @(negedge clk); wrHi = 1'b1; wrData = value;
    @(negedge clk); wrHi = 1'b0;
  endtask

  // Cycles until tick is seen, counting rising edges from the current point
  task automatic waitTick(output int cycles, output bit firstLow);
    cycles = 0;
    firstLow = 1'b1;
    for (int i = 0; i < TIMEOUT; i++) begin
      @(posedge clk); #1;
      cycles++;
      if (tick) break;
    end
    if (!tick) cycles = -1;
    if (cycles != 1) firstLow = 1'b1;
  endtask

  task automatic measure(input logic [15:0] n, input bit sel, input string req);
    int expected;
    int got;
    bit dummy;
    expected = int'(n) * (sel ? 4 : 1);
    @(negedge clk); prescaleSel = sel;
    writeDiv(n);
    waitTick(got, dummy);
    check(got == expected, {req, " R6 first tick"}, got, expected);
    for (int g = 0; g < 2; g++) begin
      @(posedge clk); #1;
      if (expected > 1)
        check(tick == 1'b0, {req, " R7 width"}, int'(tick), 0);
      if (expected == 1) got = 1;
      else begin
        waitTick(got, dummy);
        got = (got < 0) ? got : got + 1;
      end
      check(got == expected, {req, " period"}, got, expected);
    end
  endtask

  task automatic countTicks(input int span, output int seen);
    seen = 0;
    for (int i = 0; i < span; i++) begin
      @(posedge clk); #1;
      if (tick) seen++;
    end
  endtask

  initial begin
    int seen;
    int got;
    bit dummy;
    // R1: reset state
    #(CLK_PERIOD * 3 + 1);
    check(tick == 1'b0, "R1 tick low in reset", int'(tick), 0);
    @(negedge clk); rst_n = 1'b1;
    countTicks(60, seen);
    check(seen == 0, "R1 no tick after reset", seen, 0);

    // R3 / R4 sweep
    for (int n = 1; n <= 12; n++) measure(16'(n), 1'b0, "R3 div1");
    for (int n = 1; n <= 12; n++) measure(16'(n), 1'b1, "R4 div4");

    // R8 examples
    measure(16'h0001, 1'b0, "R8 unity");
    measure(16'h0900, 1'b1, "R8 0x0900/4");

    // R2: high byte only, low byte kept
    measure(16'h0005, 1'b0, "R2 base");
    writeHiOnly(8'h01);
    waitTick(got, dummy);
    check(got == 261, "R2 high-byte-only write", got, 261);
    waitTick(got, dummy);
    check(got == 261, "R2 high-byte-only period", got, 261);

    // R5: zero divisor under both prescales
    @(negedge clk); prescaleSel = 1'b0;
    writeDiv(16'h0000);
    countTicks(300, seen);
    check(seen == 0, "R5 zero divisor div1", seen, 0);
    @(negedge clk); prescaleSel = 1'b1;
    countTicks(300, seen);
    check(seen == 0, "R5 zero divisor div4", seen, 0);

    // R1: reset mid-count clears the divisor
    measure(16'h0003, 1'b0, "R1 pre-reset");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    countTicks(200, seen);
    check(seen == 0, "R1 reset clears divisor", seen, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule